// File: doc/BRIEF.md
# Predicated Segment Load-and-Replicate Unit

This block carries out a vector "load one segment and broadcast" operation. A command names a 4-bit operation selector, a 64-bit base address, either a small signed immediate or a 64-bit register offset, and a governing predicate with one bit per element. The unit works out the effective address and issues one memory read of 16 or 32 bytes. The per-byte read enables of that read follow the predicate. When the data returns, bytes of inactive elements are forced to zero. The resulting segment of one or two 128-bit lanes is then copied across the destination vector.

The vector length is given at run time as a count of 128-bit lanes, from 1 to 16. Lanes at or above that count read as zero. When the segment is two lanes wide and the lane count is odd, the last lane cannot hold a whole copy, so it is zero-filled and never partly copied. Only one operation is in flight at a time. Commands use a valid/ready handshake, the memory request is held until the memory accepts it, and the result comes back as a single-cycle pulse. A selector that names no operation gives a one-cycle error pulse and no memory traffic.

Top module: `seg_bcast_load`

## Requirements
- R1: Selector values 0x0, 0x4, 0x8, 0xC give a 16-byte segment and 0x1, 0x5, 0x9, 0xD a 32-byte segment. Bits [3:2] give the element size: 0→1 byte, 1→2, 2→4, 3→8 bytes. Any other selector value raises `err_pulse` for exactly one cycle, starting the cycle after acceptance, and issues no memory request.
- R2: In immediate mode (`cmd_imm_mode`=1) the request address is `cmd_base` plus the sign-extended 4-bit `cmd_imm` times the segment size (16 or 32).
- R3: In register mode (`cmd_imm_mode`=0) the request address is `cmd_base` plus `cmd_offset` times the element size in bytes, modulo 2^64.
- R4: `mem_req_len32` is 1 for a 32-byte segment. Byte b of `mem_req_byte_en` is set only when b lies inside the segment and predicate bit floor(b / element size) is set. Bytes 16 to 31 are clear for a 16-byte segment.
- R5: In the result, every byte of an element whose predicate bit is clear is zero. Active bytes carry `mem_rsp_data` byte for byte, with byte 0 in bits [7:0].
- R6: With a 16-byte segment and a lane count N, result lanes 0..N-1 each equal the segment, and lanes N..15 are zero. Lane i is `res_data[128*i +: 128]`.
- R7: With a 32-byte segment, lane i below N-(N mod 2) equals segment half (i mod 2), where half 0 is response bytes 0..15. Every other lane, including the last lane when N is odd, is zero.
- R8: The request stays valid, with its address, enables and length unchanged, until `mem_req_ready` is seen. `res_valid` pulses for one cycle, the cycle after the cycle in which `mem_rsp_valid` is seen.
- R9: After reset, `cmd_ready` is 1 and `mem_req_valid`, `res_valid` and `err_pulse` are 0. `cmd_ready` is 1 only while no operation is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Unit idle and able to accept a command |
| cmd_sel | input | 4 | Operation selector |
| cmd_imm_mode | input | 1 | 1: immediate offset, 0: register offset |
| cmd_base | input | 64 | Base address |
| cmd_offset | input | 64 | Register offset in elements |
| cmd_imm | input | 4 | Signed immediate offset in segments |
| cmd_pred | input | 32 | Governing predicate, one bit per element |
| cmd_vl | input | 5 | Vector length in 128-bit lanes (1 to 16) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 64 | Read address |
| mem_req_len32 | output | 1 | 1: 32-byte read, 0: 16-byte read |
| mem_req_byte_en | output | 32 | Per-byte read enables |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 256 | Read data, byte 0 in bits [7:0] |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 2048 | Assembled destination vector |
| err_pulse | output | 1 | One-cycle pulse for an undefined selector |

## Verification
The hardest case to reach is a 32-byte segment with an odd lane count, where the top copied lane must stop one lane short and the final lane must be zero rather than half a segment. The bench reaches it by sending a 32-byte command with a lane count of 5 and, separately, of 1, where nothing is copied at all. Each time it fills the two response halves with different byte patterns, so that a swapped or repeated half shows up. Request hold under back-pressure is reached by keeping `mem_req_ready` low for several cycles before the read is accepted.

// File: rtl/seg_bcast_pkg.sv
package seg_bcast_pkg;

    typedef enum logic [1:0] {
        ESZ_BYTE  = 2'd0,
        ESZ_HALF  = 2'd1,
        ESZ_WORD  = 2'd2,
        ESZ_DWORD = 2'd3
    } esz_e;

    typedef struct packed {
        logic legal;
        logic dbl;
        esz_e esz;
    } op_s;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RESP = 2'd3
    } state_e;

    function automatic op_s decode_sel(input logic [3:0] sel);
        op_s o;
        o.legal = (sel[1] == 1'b0);
        o.dbl   = sel[0];
        o.esz   = esz_e'(sel[3:2]);
        return o;
    endfunction

    function automatic logic [2:0] seg_shift(input logic dbl);
        return dbl ? 3'd5 : 3'd4;
    endfunction

endpackage

// File: rtl/sb_addr_gen.sv
module sb_addr_gen
    import seg_bcast_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int IMM_W  = 4
) (
    input  op_s               op,
    input  logic              imm_mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] offset,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] ea
);
    logic [ADDR_W-1:0] imm_ext;
    logic [ADDR_W-1:0] imm_term;
    logic [ADDR_W-1:0] reg_term;

    always_comb begin
        imm_ext  = {{(ADDR_W-IMM_W){imm[IMM_W-1]}}, imm};
        imm_term = imm_ext << seg_shift(op.dbl);
        reg_term = offset << op.esz;
        ea       = base + (imm_mode ? imm_term : reg_term);
    end
endmodule

// File: rtl/sb_byte_en.sv
module sb_byte_en
    import seg_bcast_pkg::*;
#(
    parameter int SEG_BYTES = 32
) (
    input  op_s                  op,
    input  logic [SEG_BYTES-1:0] pred,
    output logic [SEG_BYTES-1:0] byte_en
);
    localparam int IW = $clog2(SEG_BYTES);

    for (genvar b = 0; b < SEG_BYTES; b++) begin : g_byte
        logic [IW-1:0] elem_idx;
        assign elem_idx = IW'(b) >> op.esz;
        if (b < SEG_BYTES/2) begin : g_low
            assign byte_en[b] = pred[elem_idx];
        end else begin : g_high
            assign byte_en[b] = op.dbl & pred[elem_idx];
        end
    end
endmodule

// File: rtl/sb_replicate.sv
module sb_replicate #(
    parameter int LANE_W    = 128,
    parameter int MAX_LANES = 16,
    parameter int LCW       = $clog2(MAX_LANES+1)
) (
    input  logic [2*LANE_W-1:0]         rsp,
    input  logic [2*LANE_W/8-1:0]       byte_en,
    input  logic                        dbl,
    input  logic [LCW-1:0]              vl,
    output logic [LANE_W*MAX_LANES-1:0] vec
);
    localparam int SEG_BYTES = 2*LANE_W/8;

    logic [2*LANE_W-1:0] seg;
    logic [LCW-1:0]      full;

    for (genvar b = 0; b < SEG_BYTES; b++) begin : g_mask
        assign seg[8*b +: 8] = byte_en[b] ? rsp[8*b +: 8] : 8'h00;
    end

    assign full = dbl ? {vl[LCW-1:1], 1'b0} : vl;

    for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
        localparam int HALF = i % 2;
        logic [LANE_W-1:0] src;
        assign src = dbl ? seg[HALF*LANE_W +: LANE_W] : seg[0 +: LANE_W];
        assign vec[i*LANE_W +: LANE_W] = (LCW'(i) < full) ? src : '0;
    end
endmodule

// File: rtl/seg_bcast_load.sv
module seg_bcast_load
    import seg_bcast_pkg::*;
#(
    parameter int ADDR_W    = 64,
    parameter int LANE_W    = 128,
    parameter int MAX_LANES = 16,
    parameter int IMM_W     = 4,
    parameter int SEG_BYTES = 2*LANE_W/8,
    parameter int LCW       = $clog2(MAX_LANES+1),
    parameter int VEC_W     = LANE_W*MAX_LANES
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [3:0]           cmd_sel,
    input  logic                 cmd_imm_mode,
    input  logic [ADDR_W-1:0]    cmd_base,
    input  logic [ADDR_W-1:0]    cmd_offset,
    input  logic [IMM_W-1:0]     cmd_imm,
    input  logic [SEG_BYTES-1:0] cmd_pred,
    input  logic [LCW-1:0]       cmd_vl,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic                 mem_req_len32,
    output logic [SEG_BYTES-1:0] mem_req_byte_en,
    input  logic                 mem_rsp_valid,
    input  logic [8*SEG_BYTES-1:0] mem_rsp_data,
    output logic                 res_valid,
    output logic [VEC_W-1:0]     res_data,
    output logic                 err_pulse
);
    state_e               state;
    op_s                  op_in;
    op_s                  op_q;
    logic [ADDR_W-1:0]    ea_in;
    logic [ADDR_W-1:0]    ea_q;
    logic [SEG_BYTES-1:0] be_in;
    logic [SEG_BYTES-1:0] be_q;
    logic [LCW-1:0]       vl_q;
    logic [VEC_W-1:0]     vec_in;
    logic [VEC_W-1:0]     res_q;
    logic                 res_v;
    logic                 err_q;

    assign op_in = decode_sel(cmd_sel);

    sb_addr_gen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
        .op       (op_in),
        .imm_mode (cmd_imm_mode),
        .base     (cmd_base),
        .offset   (cmd_offset),
        .imm      (cmd_imm),
        .ea       (ea_in)
    );

    sb_byte_en #(.SEG_BYTES(SEG_BYTES)) u_be (
        .op      (op_in),
        .pred    (cmd_pred),
        .byte_en (be_in)
    );

    sb_replicate #(.LANE_W(LANE_W), .MAX_LANES(MAX_LANES), .LCW(LCW)) u_rep (
        .rsp     (mem_rsp_data),
        .byte_en (be_q),
        .dbl     (op_q.dbl),
        .vl      (vl_q),
        .vec     (vec_in)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            op_q  <= '0;
            ea_q  <= '0;
            be_q  <= '0;
            vl_q  <= '0;
            res_q <= '0;
            res_v <= 1'b0;
            err_q <= 1'b0;
        end else begin
            res_v <= 1'b0;
            err_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        if (op_in.legal) begin
                            op_q  <= op_in;
                            ea_q  <= ea_in;
                            be_q  <= be_in;
                            vl_q  <= cmd_vl;
                            state <= ST_REQ;
                        end else begin
                            err_q <= 1'b1;
                        end
                    end
                end
                ST_REQ: begin
                    if (mem_req_ready) state <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        res_q <= vec_in;
                        res_v <= 1'b1;
                        state <= ST_RESP;
                    end
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign cmd_ready       = (state == ST_IDLE);
    assign mem_req_valid   = (state == ST_REQ);
    assign mem_req_addr    = ea_q;
    assign mem_req_len32   = op_q.dbl;
    assign mem_req_byte_en = be_q;
    assign res_valid       = res_v;
    assign res_data        = res_q;
    assign err_pulse       = err_q;
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int ADDR_W    = 64,
    parameter int SEG_BYTES = 32
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_ready,
    input logic                 mem_req_valid,
    input logic                 mem_req_ready,
    input logic [ADDR_W-1:0]    mem_req_addr,
    input logic                 mem_req_len32,
    input logic [SEG_BYTES-1:0] mem_req_byte_en,
    input logic                 mem_rsp_valid,
    input logic                 res_valid,
    input logic                 err_pulse
);
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_byte_en)
             && $stable(mem_req_len32)));

    assert_res_single_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);

    assert_res_after_rsp_R8: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $past(mem_rsp_valid));

    assert_err_no_req_R1: assert property (@(posedge clk) disable iff (rst)
        err_pulse |-> (!mem_req_valid && cmd_ready));

    assert_short_be_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_len32) |-> (mem_req_byte_en[SEG_BYTES-1:SEG_BYTES/2] == '0));

    assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid || res_valid) |-> !cmd_ready);
endmodule

bind seg_bcast_load sb_checker #(.ADDR_W(ADDR_W), .SEG_BYTES(SEG_BYTES)) u_sb_checker (
    .clk             (clk),
    .rst             (rst),
    .cmd_ready       (cmd_ready),
    .mem_req_valid   (mem_req_valid),
    .mem_req_ready   (mem_req_ready),
    .mem_req_addr    (mem_req_addr),
    .mem_req_len32   (mem_req_len32),
    .mem_req_byte_en (mem_req_byte_en),
    .mem_rsp_valid   (mem_rsp_valid),
    .res_valid       (res_valid),
    .err_pulse       (err_pulse)
);

// File: tb/test_seg_bcast_load.sv
module test_seg_bcast_load;
    localparam int CLK_PERIOD = 10;
    localparam int VEC_W = 2048;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cmd_valid = 1'b0;
    logic          cmd_ready;
    logic [3:0]    cmd_sel = '0;
    logic          cmd_imm_mode = 1'b0;
    logic [63:0]   cmd_base = '0;
    logic [63:0]   cmd_offset = '0;
    logic [3:0]    cmd_imm = '0;
    logic [31:0]   cmd_pred = '0;
    logic [4:0]    cmd_vl = 5'd1;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b0;
    logic [63:0]   mem_req_addr;
    logic          mem_req_len32;
    logic [31:0]   mem_req_byte_en;
    logic          mem_rsp_valid = 1'b0;
    logic [255:0]  mem_rsp_data = '0;
    logic          res_valid;
    logic [VEC_W-1:0] res_data;
    logic          err_pulse;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    seg_bcast_load i_seg_bcast_load (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_sel(cmd_sel),
        .cmd_imm_mode(cmd_imm_mode), .cmd_base(cmd_base), .cmd_offset(cmd_offset),
        .cmd_imm(cmd_imm), .cmd_pred(cmd_pred), .cmd_vl(cmd_vl),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_req_len32(mem_req_len32),
        .mem_req_byte_en(mem_req_byte_en), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .res_valid(res_valid), .res_data(res_data),
        .err_pulse(err_pulse)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_vec(input string tag, input logic [VEC_W-1:0] act,
                             input logic [VEC_W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            for (int i = 0; i < 16; i++) begin
                if (act[128*i +: 128] !== exp[128*i +: 128]) begin
                    $display("FAIL %s lane %0d actual=%h expected=%h", tag, i,
                             act[128*i +: 128], exp[128*i +: 128]);
                    break;
                end
            end
        end
    endtask

    function automatic logic [255:0] pattern(input logic [7:0] seed);
        logic [255:0] d;
        for (int b = 0; b < 32; b++) d[8*b +: 8] = seed + 8'(b * 13) + ((b >= 16) ? 8'h80 : 8'h00);
        return d;
    endfunction

    function automatic logic [31:0] exp_be(input logic [3:0] sel, input logic [31:0] pred);
        logic [31:0] e;
        int esize = 1 << sel[3:2];
        int segb  = sel[0] ? 32 : 16;
        for (int b = 0; b < 32; b++) e[b] = (b < segb) && pred[b / esize];
        return e;
    endfunction

    function automatic logic [VEC_W-1:0] exp_vec(input logic [3:0] sel, input logic [31:0] pred,
                                                  input logic [255:0] data, input int vl);
        logic [VEC_W-1:0] v = '0;
        logic [255:0] seg;
        logic [31:0] be = exp_be(sel, pred);
        int s = sel[0] ? 2 : 1;
        int full = vl - (vl % s);
        for (int b = 0; b < 32; b++) seg[8*b +: 8] = be[b] ? data[8*b +: 8] : 8'h00;
        for (int i = 0; i < full; i++) v[128*i +: 128] = seg[128*(i % s) +: 128];
        return v;
    endfunction

    // Runs one legal operation and checks address, enables, length, hold, result.
    task automatic run_op(input string tag, input logic [3:0] sel, input logic immm,
                          input logic [63:0] base, input logic [63:0] off, input logic [3:0] imm,
                          input logic [31:0] pred, input int vl, input logic [7:0] seed,
                          input int stall, input logic [63:0] want_addr);
        logic [63:0] a0;
        logic [31:0] b0;
        logic        l0;
        bit          held = 1;
        logic [255:0] d = pattern(seed);
        @(negedge clk);
        cmd_sel = sel; cmd_imm_mode = immm; cmd_base = base; cmd_offset = off;
        cmd_imm = imm; cmd_pred = pred; cmd_vl = 5'(vl); cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check64({tag, " R8 req valid"}, 64'(mem_req_valid), 64'd1);
        a0 = mem_req_addr; b0 = mem_req_byte_en; l0 = mem_req_len32;
        check64({tag, (immm ? " R2 addr" : " R3 addr")}, a0, want_addr);
        check64({tag, " R4 byte_en"}, 64'(b0), 64'(exp_be(sel, pred)));
        check64({tag, " R4 len32"}, 64'(l0), 64'(sel[0]));
        for (int k = 0; k < stall; k++) begin
            @(negedge clk);
            if (!mem_req_valid || mem_req_addr !== a0 || mem_req_byte_en !== b0
                || mem_req_len32 !== l0) held = 0;
        end
        if (stall > 0) check64({tag, " R8 hold under stall"}, 64'(held), 64'd1);
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_data = d;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = '0;
        check64({tag, " R8 res pulse"}, 64'(res_valid), 64'd1);
        check_vec({tag, (sel[0] ? " R7/R5 result" : " R6/R5 result")}, res_data,
                  exp_vec(sel, pred, d, vl));
        @(negedge clk);
        check64({tag, " R8 res single"}, 64'(res_valid), 64'd0);
        check64({tag, " R9 ready again"}, 64'(cmd_ready), 64'd1);
    endtask

    task automatic t_reset();
        check64("R9 reset cmd_ready", 64'(cmd_ready), 64'd1);
        check64("R9 reset req_valid", 64'(mem_req_valid), 64'd0);
        check64("R9 reset res_valid", 64'(res_valid), 64'd0);
        check64("R9 reset err", 64'(err_pulse), 64'd0);
    endtask

    task automatic t_illegal(input logic [3:0] sel);
        @(negedge clk);
        cmd_sel = sel; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        check64("R1 err pulse", 64'(err_pulse), 64'd1);
        check64("R1 no request", 64'(mem_req_valid), 64'd0);
        @(negedge clk);
        check64("R1 err one cycle", 64'(err_pulse), 64'd0);
        check64("R1 still no request", 64'(mem_req_valid), 64'd0);
    endtask

    task automatic t_imm_byte16();
        // 16-byte, 1-byte elements, imm -1: 0x1000 - 16; all active, 4 lanes
        run_op("imm_b16", 4'h0, 1'b1, 64'h1000, 64'd0, 4'hF, 32'h0000FFFF, 4, 8'h11, 0, 64'h0FF0);
    endtask

    task automatic t_imm_byte32_neg();
        // 32-byte, imm -2: 0x1000 - 64; vl 16, scattered predicate
        run_op("imm_b32", 4'h1, 1'b1, 64'h1000, 64'd0, 4'hE, 32'hA5C3_0F71, 16, 8'h22, 0, 64'h0FC0);
    endtask

    task automatic t_reg_half32_odd();
        // 32-byte, 2-byte elements, offset 3 -> +6; vl 5 so lane 4 zero
        run_op("reg_h32_odd", 4'h5, 1'b0, 64'h2000, 64'd3, 4'h0, 32'h0000_B6FF, 5, 8'h33, 3, 64'h2006);
    endtask

    task automatic t_reg_word16_pred();
        // 16-byte, 4-byte elements, offset 2 -> +8; elements 1 and 3 inactive
        run_op("reg_w16", 4'h8, 1'b0, 64'h3000, 64'd2, 4'h0, 32'hFFFF_FFF5, 7, 8'h44, 2, 64'h3008);
    endtask

    task automatic t_reg_dword32();
        // 32-byte, 8-byte elements, offset 5 -> +40; element 2 inactive; vl 16
        run_op("reg_d32", 4'hD, 1'b0, 64'h4000, 64'd5, 4'h0, 32'h0000_000B, 16, 8'h55, 1, 64'h4028);
    endtask

    task automatic t_vl1_32();
        // 32-byte segment with a single lane: nothing fits, all zero; imm +7 -> +224
        run_op("vl1_b32", 4'h9, 1'b1, 64'h5000, 64'd0, 4'h7, 32'hFFFF_FFFF, 1, 8'h66, 0, 64'h50E0);
    endtask

    task automatic t_dword16_wrap();
        // 16-byte, 8-byte elements, offset all ones -> base - 8; vl 1
        run_op("reg_d16", 4'hC, 1'b0, 64'h10, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0, 32'h2, 1, 8'h77, 0, 64'h8);
    endtask

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_illegal(4'h2);
        t_illegal(4'hF);
        t_imm_byte16();
        t_imm_byte32_neg();
        t_reg_half32_odd();
        t_reg_word16_pred();
        t_reg_dword32();
        t_vl1_32();
        t_dword16_wrap();
        t_illegal(4'h6);
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule